// File: doc/BRIEF.md
# Low-Power Lane Request Detector

This block watches the two single-ended low-power wires of one serial data lane. Their levels arrive as a 2-bit line code on a fast system clock. Glitches are assumed to be filtered upstream. The block waits for the lane to sit in the stop state (both wires high). From there it recognises three ordered request sequences: entry into escape signalling, entry into high-speed transmission, and a bus turnaround. When a sequence completes, it raises a single-cycle pulse on the matching output.

A line level counts as a step only after it has been stable for `STABLE_CYC` consecutive samples. Repeated samples of the level already accepted never count as a new step. A level that does not fit the sequence in progress gives an error pulse, and the block waits for the stop state again. After any completed request the lane is treated as busy. High-speed data, escape traffic or turnaround activity may then toggle the wires freely until the stop state returns. A `stop_state` level tells the surrounding logic that the lane is idle.

Top module: `lp_req_detect`

## Requirements
- R1: While `rst_n` is low and until a line level has qualified, `esc_req`, `hs_req`, `turn_req`, `seq_err` and `stop_state` are all 0.
- R2: `line_st` is {Dp, Dn}; code 2'b11 is the stop state. Once 2'b11 has been sampled on `STABLE_CYC` consecutive clocks, `stop_state` is 1 from the next clock on. It stays 1 until a different level qualifies.
- R3: A level held for fewer than `STABLE_CYC` consecutive samples is not a step. It advances no sequence, raises no error and leaves `stop_state` unchanged. A level equal to the last accepted one is never a new step.
- R4: From stop, the steps 2'b10, 2'b00, 2'b01, 2'b00 give `esc_req`. The pulse is high for exactly the one clock after the sample that qualifies the final 2'b00.
- R5: From stop, the steps 2'b01, 2'b00 give a one-cycle `hs_req` with the same timing as R4.
- R6: From stop, the steps 2'b10, 2'b00, 2'b10, 2'b00 give a one-cycle `turn_req` with the same timing as R4.
- R7: After any request, every level other than 2'b11 is ignored: no pulse, no error, `stop_state` 0. This holds until 2'b11 qualifies again, which sets `stop_state`.
- R8: A qualified step that breaks a sequence raises `seq_err` for one clock and no request. If that step is 2'b11 the block is back in stop. Otherwise it waits for 2'b11 and raises no further error meanwhile.
- R9: `stop_state` is 0 from the first step of a sequence until the lane qualifies 2'b11 again.
- R10: At most one of `esc_req`, `hs_req`, `turn_req`, `seq_err` is high in any clock, and none stays high for two consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_st | input | 2 | Low-power line code {Dp, Dn} |
| esc_req | output | 1 | Escape entry request pulse |
| hs_req | output | 1 | High-speed entry request pulse |
| turn_req | output | 1 | Turnaround request pulse |
| stop_state | output | 1 | Lane idle in stop state |
| seq_err | output | 1 | Broken sequence pulse |

## Verification
The hardest case to reach from the ports is a short glitch in the middle of a sequence. The glitch must pull the stability counter away and then return to the level already accepted. The test must show that this neither re-qualifies the old level as a new step nor counts the glitch as a step. The bench drives the escape sequence with a two-sample 2'b00 glitch inside the 2'b10 step. It then expects exactly one escape pulse and no error. A second glitch, driven while the lane sits in stop, must leave `stop_state` high throughout.

// File: rtl/lp_req_detect.sv
module lp_req_detect #(
  parameter int STABLE_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] line_st,
  output logic       esc_req,
  output logic       hs_req,
  output logic       turn_req,
  output logic       stop_state,
  output logic       seq_err
);

  localparam int CW = $clog2(STABLE_CYC + 1);
  localparam logic [CW-1:0] CMAX = CW'(STABLE_CYC);
  localparam logic [1:0] LP00 = 2'b00, LP01 = 2'b01, LP10 = 2'b10, LP11 = 2'b11;

  typedef enum logic [2:0] {
    WAIT11, STOP, E1, E2, ESC3, TA3, HS1, BUSY
  } st_t;

  st_t st, st_nx;
  logic [1:0] cand, acc;
  logic [CW-1:0] cnt, cnt_nx;
  logic same, step;
  logic esc_nx, hs_nx, turn_nx, err_nx;

  assign same   = (line_st == cand);
  assign cnt_nx = !same ? CW'(1) : (cnt == CMAX) ? cnt : cnt + CW'(1);
  assign step   = (cnt_nx == CMAX) && !(same && cnt == CMAX) && (line_st != acc);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cand <= LP00;
      acc  <= LP00;
      cnt  <= '0;
    end else begin
      cand <= line_st;
      cnt  <= cnt_nx;
      if (step) acc <= line_st;
    end
  end

  always_comb begin
    st_nx   = st;
    esc_nx  = 1'b0;
    hs_nx   = 1'b0;
    turn_nx = 1'b0;
    err_nx  = 1'b0;
    if (step) begin
      unique case (st)
        WAIT11, BUSY: if (line_st == LP11) st_nx = STOP;
        STOP: begin
          if (line_st == LP10)      st_nx = E1;
          else if (line_st == LP01) st_nx = HS1;
          else begin st_nx = WAIT11; err_nx = 1'b1; end
        end
        E1: begin
          if (line_st == LP00) st_nx = E2;
          else begin st_nx = (line_st == LP11) ? STOP : WAIT11; err_nx = 1'b1; end
        end
        E2: begin
          if (line_st == LP01)      st_nx = ESC3;
          else if (line_st == LP10) st_nx = TA3;
          else begin st_nx = STOP; err_nx = 1'b1; end
        end
        ESC3: begin
          if (line_st == LP00) begin st_nx = BUSY; esc_nx = 1'b1; end
          else begin st_nx = (line_st == LP11) ? STOP : WAIT11; err_nx = 1'b1; end
        end
        TA3: begin
          if (line_st == LP00) begin st_nx = BUSY; turn_nx = 1'b1; end
          else begin st_nx = (line_st == LP11) ? STOP : WAIT11; err_nx = 1'b1; end
        end
        HS1: begin
          if (line_st == LP00) begin st_nx = BUSY; hs_nx = 1'b1; end
          else begin st_nx = (line_st == LP11) ? STOP : WAIT11; err_nx = 1'b1; end
        end
        default: st_nx = WAIT11;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= WAIT11;
      esc_req  <= 1'b0;
      hs_req   <= 1'b0;
      turn_req <= 1'b0;
      seq_err  <= 1'b0;
    end else begin
      st       <= st_nx;
      esc_req  <= esc_nx;
      hs_req   <= hs_nx;
      turn_req <= turn_nx;
      seq_err  <= err_nx;
    end
  end

  assign stop_state = (st == STOP);

endmodule

// File: rtl/lp_req_detect_chk.sv
module lp_req_detect_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] line_st,
  input logic       esc_req,
  input logic       hs_req,
  input logic       turn_req,
  input logic       stop_state,
  input logic       seq_err
);

  assert_one_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({esc_req, hs_req, turn_req, seq_err}));

  assert_esc_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    esc_req |=> !esc_req);

  assert_hs_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hs_req |=> !hs_req);

  assert_turn_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    turn_req |=> !turn_req);

  assert_req_on_lp00_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (esc_req || hs_req || turn_req) |-> $past(line_st) == 2'b00);

  assert_stop_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_state) |-> $past(line_st) == 2'b11);

  assert_req_not_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (esc_req || hs_req || turn_req) |-> !stop_state);

endmodule

bind lp_req_detect lp_req_detect_chk u_chk (.*);

// File: tb/tb_lp_req_detect.sv
module tb_lp_req_detect;
  localparam int ST = 4;
  localparam int HOLD = 6;

  logic clk = 0, rst_n = 0;
  logic [1:0] line_st = 2'b11;
  logic esc_req, hs_req, turn_req, stop_state, seq_err;
  int n_chk = 0, n_fail = 0, cyc = 0;
  int n_esc = 0, n_hs = 0, n_turn = 0, n_err = 0, n_wide = 0;
  logic prev_any = 0;
  bit done = 0;

  always #4 clk = ~clk;

  lp_req_detect #(.STABLE_CYC(ST)) dut (.*);

  always @(negedge clk) begin
    if (esc_req) n_esc++;
    if (hs_req) n_hs++;
    if (turn_req) n_turn++;
    if (seq_err) n_err++;
    if (prev_any && (esc_req || hs_req || turn_req || seq_err)) n_wide++;
    prev_any = esc_req || hs_req || turn_req || seq_err;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: act=%0d cycles exp<=20000", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] v, input int n);
    @(negedge clk) line_st = v;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 0; line_st = 2'b11;
    repeat (3) @(negedge clk);
    check({esc_req, hs_req, turn_req, seq_err, stop_state} == 0, "R1 in reset",
          {esc_req, hs_req, turn_req, seq_err, stop_state}, 0);
    rst_n = 1;
    repeat (ST - 1) @(negedge clk);
    check(stop_state == 0, "R1 before qualify", stop_state, 0);
    @(negedge clk);
    check(stop_state == 1, "R2 stop after qualify", stop_state, 1);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_escape;
    int e0 = n_esc, r0 = n_err;
    drive(2'b10, HOLD);
    check(stop_state == 0, "R9 stop low in seq", stop_state, 0);
    drive(2'b00, HOLD);
    drive(2'b01, HOLD);
    @(negedge clk) line_st = 2'b00;
    repeat (ST - 1) @(negedge clk);
    check(esc_req == 0, "R4 esc not early", esc_req, 0);
    @(negedge clk);
    check(esc_req == 1, "R4 esc pulse", esc_req, 1);
    @(negedge clk);
    check(esc_req == 0, "R4 esc one cycle", esc_req, 0);
    drive(2'b11, HOLD);
    check(n_esc - e0 == 1 && n_err == r0, "R4 esc count", n_esc - e0, 1);
    check(stop_state == 1, "R7 back to stop", stop_state, 1);
  endtask

  task automatic t_hs;
    int h0 = n_hs, r0 = n_err, e0 = n_esc, t0 = n_turn;
    drive(2'b01, HOLD);
    drive(2'b00, HOLD);
    check(n_hs - h0 == 1, "R5 hs pulse", n_hs - h0, 1);
    drive(2'b01, HOLD); drive(2'b10, HOLD); drive(2'b00, HOLD);
    drive(2'b01, HOLD); drive(2'b00, HOLD);
    check(n_err == r0 && n_esc == e0 && n_turn == t0 && n_hs - h0 == 1,
          "R7 busy ignores", n_err - r0 + n_esc - e0 + n_turn - t0 + n_hs - h0, 1);
    check(stop_state == 0, "R7 busy not stop", stop_state, 0);
    drive(2'b11, HOLD);
    check(stop_state == 1, "R7 stop returns", stop_state, 1);
  endtask

  task automatic t_turn;
    int t0 = n_turn, e0 = n_esc, r0 = n_err;
    drive(2'b10, HOLD); drive(2'b00, HOLD); drive(2'b10, HOLD); drive(2'b00, HOLD);
    check(n_turn - t0 == 1 && n_esc == e0 && n_err == r0, "R6 turn pulse", n_turn - t0, 1);
    drive(2'b11, HOLD);
  endtask

  task automatic t_glitch;
    int e0 = n_esc, r0 = n_err;
    drive(2'b00, ST - 2);
    drive(2'b11, HOLD);
    check(stop_state == 1 && n_err == r0, "R3 glitch in stop", stop_state, 1);
    drive(2'b10, HOLD);
    drive(2'b00, 2);
    drive(2'b10, HOLD);
    drive(2'b00, HOLD); drive(2'b01, HOLD); drive(2'b00, HOLD);
    check(n_esc - e0 == 1 && n_err == r0, "R3 glitch in sequence", n_esc - e0, 1);
    drive(2'b11, HOLD);
  endtask

  task automatic t_break;
    int r0 = n_err, e0 = n_esc, h0 = n_hs, t0 = n_turn;
    drive(2'b10, HOLD);
    drive(2'b01, HOLD);
    check(n_err - r0 == 1, "R8 err pulse", n_err - r0, 1);
    check(stop_state == 0, "R8 waiting", stop_state, 0);
    drive(2'b00, HOLD); drive(2'b01, HOLD);
    check(n_err - r0 == 1, "R8 no further err", n_err - r0, 1);
    drive(2'b11, HOLD);
    check(stop_state == 1, "R8 recover", stop_state, 1);
    drive(2'b10, HOLD);
    drive(2'b11, HOLD);
    check(n_err - r0 == 2 && stop_state == 1, "R8 break to stop", n_err - r0, 2);
    check(n_esc == e0 && n_hs == h0 && n_turn == t0, "R8 no request",
          n_esc - e0 + n_hs - h0 + n_turn - t0, 0);
  endtask

  initial begin
    t_reset;
    t_escape;
    t_hs;
    t_turn;
    t_glitch;
    t_break;
    check(n_wide == 0, "R10 single cycle pulses", n_wide, 0);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule